// File: doc/BRIEF.md
# Dual-Width Register ALU

This block is the purely combinational execution stage of a 64-bit register-machine datapath. It receives an operation code and the current value of the destination register. It also receives a second operand, which is either a source register value or a 32-bit immediate. It returns the value to be written back into the destination register. The destination behaves as an accumulator: every two-operand operation computes `dst op second`, and single-operand operations transform `dst` alone.

Every arithmetic, logic, shift, negate, move and sign-extending move operation runs in either a full 64-bit form or a 32-bit subregister form, chosen by a width-mode input. The byte-order operations take their width, 8, 16, 32 or 64 bits, from a size field. They convert to little-endian or big-endian order, or reverse the byte order. A separate output flags any unsigned divide or remainder whose divisor is zero. Register-file access, decode and memory traffic belong to the surrounding pipeline.

Top module: `dual_width_alu`

## Requirements
- R1: Opcode `op_i` encodings are: 0 add, 1 subtract, 2 multiply. Each result wraps modulo 2^64 in 64-bit mode.
- R2: Opcodes 3 (unsigned divide) and 4 (unsigned remainder) return the quotient and the remainder. When the divisor is zero, divide returns 0, remainder returns the destination unchanged, and `divz_o` is 1. In every other case `divz_o` is 0.
- R3: Opcodes 5, 6 and 7 return the bitwise AND, OR and XOR of the two operands.
- R4: Opcodes 8 (left shift), 9 (logical right shift) and 10 (arithmetic right shift) shift the destination. The shift amount is the low 6 bits of the second operand in 64-bit mode and the low 5 bits in 32-bit mode. An arithmetic shift replicates bit 63 in 64-bit mode and bit 31 in 32-bit mode.
- R5: Opcode 11 returns the two's-complement negation of the destination. Opcode 12 returns the second operand.
- R6: When `use_imm_i` is 1, the second operand is `imm_i` sign-extended from bit 31. Otherwise it is `src_i`.
- R7: When `w32_i` is 1, opcodes 0 to 13 use only the low 32 bits of each operand, and result bits 63:32 are 0.
- R8: Opcode 13 sign-extends the low 8, 16 or 32 bits of the second operand for `size_i` = 0, 1 or 2. When `size_i` is 3, it copies the operand unchanged.
- R9: Opcode 14 (to little-endian) keeps the low 8<<`size_i` bits of the destination and zero-extends them.
- R10: Opcodes 15 (to big-endian) and 16 (byte swap) reverse the byte order within the low 8<<`size_i` bits of the destination and zero-extend the result. Opcodes 14 to 16 ignore `w32_i`.
- R11: Opcodes 17 to 31 return the destination unchanged and leave `divz_o` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_i | input | 5 | Operation code |
| w32_i | input | 1 | 1 selects 32-bit subregister mode |
| use_imm_i | input | 1 | 1 selects the immediate as the second operand |
| size_i | input | 2 | Width field for sign-extending moves and byte-order operations |
| dst_i | input | 64 | Current destination register value |
| src_i | input | 64 | Source register value |
| imm_i | input | 32 | Immediate field, two's complement |
| res_o | output | 64 | New destination value |
| divz_o | output | 1 | Divide or remainder by zero occurred |

## Verification
The checks assume that every input is a known 0 or 1 and that the inputs hold still while the outputs are examined. Because the block has no state, each check is only valid on the settled combinational outputs. The bench changes the inputs only on the falling clock edge and reads the outputs a few nanoseconds later, so the outputs have always settled and the inputs never carry unknown bits. The stimulus covers both width modes and both operand sources, zero and non-zero divisors, shift counts above the mask, and each size code on the byte-order paths.

// File: rtl/dwalu_pkg.sv
package dwalu_pkg;

  typedef enum logic [4:0] {
    OP_ADD   = 5'd0,
    OP_SUB   = 5'd1,
    OP_MUL   = 5'd2,
    OP_DIV   = 5'd3,
    OP_MOD   = 5'd4,
    OP_AND   = 5'd5,
    OP_OR    = 5'd6,
    OP_XOR   = 5'd7,
    OP_SHL   = 5'd8,
    OP_SHR   = 5'd9,
    OP_SAR   = 5'd10,
    OP_NEG   = 5'd11,
    OP_MOV   = 5'd12,
    OP_MOVSX = 5'd13,
    OP_TOLE  = 5'd14,
    OP_TOBE  = 5'd15,
    OP_BSWAP = 5'd16
  } alu_op_e;

  typedef enum logic [1:0] {
    CLS_ARITH = 2'd0,
    CLS_SHLOG = 2'd1,
    CLS_BYTE  = 2'd2,
    CLS_PASS  = 2'd3
  } alu_cls_e;

  function automatic alu_cls_e op_class(input logic [4:0] op);
    case (op)
      OP_ADD, OP_SUB, OP_MUL, OP_DIV, OP_MOD, OP_NEG, OP_MOV: op_class = CLS_ARITH;
      OP_AND, OP_OR, OP_XOR, OP_SHL, OP_SHR, OP_SAR:          op_class = CLS_SHLOG;
      OP_MOVSX, OP_TOLE, OP_TOBE, OP_BSWAP:                   op_class = CLS_BYTE;
      default:                                                op_class = CLS_PASS;
    endcase
  endfunction

endpackage

// File: rtl/dwalu_operand.sv
module dwalu_operand #(
  parameter int unsigned XLEN = 64,
  parameter int unsigned IMMW = 32
) (
  input  logic            w32_i,
  input  logic            use_imm_i,
  input  logic [XLEN-1:0] dst_i,
  input  logic [XLEN-1:0] src_i,
  input  logic [IMMW-1:0] imm_i,
  output logic [XLEN-1:0] a_o,
  output logic [XLEN-1:0] b_o,
  output logic            b_zero_o
);
  localparam int unsigned HALF = XLEN / 2;
  localparam logic [XLEN-1:0] LOW_MASK = {XLEN{1'b1}} >> (XLEN - HALF);

  logic [XLEN-1:0] imm_ext;
  logic [XLEN-1:0] second;

  // sign extension through an arithmetic shift avoids zero-width replication
  always_comb begin
    imm_ext = XLEN'($signed({imm_i, {(XLEN-IMMW){1'b0}}}) >>> (XLEN - IMMW));
    second  = use_imm_i ? imm_ext : src_i;
    a_o     = w32_i ? (dst_i & LOW_MASK) : dst_i;
    b_o     = w32_i ? (second & LOW_MASK) : second;
    b_zero_o = (b_o == '0);
  end
endmodule

// File: rtl/dwalu_arith.sv
module dwalu_arith
  import dwalu_pkg::*;
#(
  parameter int unsigned XLEN = 64
) (
  input  logic [4:0]      op_i,
  input  logic [XLEN-1:0] a_i,
  input  logic [XLEN-1:0] b_i,
  input  logic            b_zero_i,
  output logic [XLEN-1:0] res_o,
  output logic            divz_o
);
  logic [XLEN-1:0] quot;
  logic [XLEN-1:0] rem;

  always_comb begin
    quot = b_zero_i ? '0 : (a_i / b_i);
    rem  = b_zero_i ? a_i : (a_i % b_i);
    divz_o = 1'b0;
    case (op_i)
      OP_ADD:  res_o = a_i + b_i;
      OP_SUB:  res_o = a_i - b_i;
      OP_MUL:  res_o = a_i * b_i;
      OP_DIV:  begin res_o = quot; divz_o = b_zero_i; end
      OP_MOD:  begin res_o = rem;  divz_o = b_zero_i; end
      OP_NEG:  res_o = '0 - a_i;
      OP_MOV:  res_o = b_i;
      default: res_o = a_i;
    endcase
  end
endmodule

// File: rtl/dwalu_shlog.sv
module dwalu_shlog
  import dwalu_pkg::*;
#(
  parameter int unsigned XLEN = 64
) (
  input  logic [4:0]      op_i,
  input  logic            w32_i,
  input  logic [XLEN-1:0] a_i,
  input  logic [XLEN-1:0] b_i,
  output logic [XLEN-1:0] res_o
);
  localparam int unsigned HALF = XLEN / 2;
  localparam int unsigned SHW  = $clog2(XLEN);

  logic [SHW-1:0]         shamt;
  logic signed [XLEN-1:0] sar_src;

  always_comb begin
    shamt   = w32_i ? {1'b0, b_i[SHW-2:0]} : b_i[SHW-1:0];
    // in 32-bit mode the sign lives in bit HALF-1
    sar_src = w32_i ? ($signed({a_i[HALF-1:0], {HALF{1'b0}}}) >>> HALF) : $signed(a_i);
    case (op_i)
      OP_AND:  res_o = a_i & b_i;
      OP_OR:   res_o = a_i | b_i;
      OP_XOR:  res_o = a_i ^ b_i;
      OP_SHL:  res_o = a_i << shamt;
      OP_SHR:  res_o = a_i >> shamt;
      OP_SAR:  res_o = XLEN'(sar_src >>> shamt);
      default: res_o = a_i;
    endcase
  end
endmodule

// File: rtl/dwalu_byteorder.sv
module dwalu_byteorder
  import dwalu_pkg::*;
#(
  parameter int unsigned XLEN = 64
) (
  input  logic [4:0]                       op_i,
  input  logic [$clog2($clog2(XLEN/8)+1)-1:0] size_i,
  input  logic [XLEN-1:0]                  dst_i,
  input  logic [XLEN-1:0]                  b_i,
  output logic [XLEN-1:0]                  res_o
);
  localparam int unsigned NBYTES = XLEN / 8;
  localparam int unsigned NSZ    = $clog2(NBYTES) + 1;

  logic [XLEN-1:0] trunc_w [NSZ];
  logic [XLEN-1:0] rev_w   [NSZ];
  logic [XLEN-1:0] sext_w  [NSZ];

  for (genvar s = 0; s < NSZ; s++) begin : g_sz
    localparam int unsigned NB = 1 << s;
    localparam int unsigned BW = 8 * NB;
    localparam logic [XLEN-1:0] KEEP = {XLEN{1'b1}} >> (XLEN - BW);

    logic [XLEN-1:0]        rv;
    logic signed [XLEN-1:0] up;

    for (genvar i = 0; i < NBYTES; i++) begin : g_byte
      if (i < NB) begin : g_in
        assign rv[8*i +: 8] = dst_i[8*(NB-1-i) +: 8];
      end else begin : g_out
        assign rv[8*i +: 8] = 8'h00;
      end
    end

    assign up         = b_i << (XLEN - BW);
    assign trunc_w[s] = dst_i & KEEP;
    assign rev_w[s]   = rv;
    assign sext_w[s]  = XLEN'(up >>> (XLEN - BW));
  end

  always_comb begin
    case (op_i)
      OP_MOVSX:         res_o = sext_w[size_i];
      OP_TOLE:          res_o = trunc_w[size_i];
      OP_TOBE, OP_BSWAP: res_o = rev_w[size_i];
      default:          res_o = dst_i;
    endcase
  end
endmodule

// File: rtl/dual_width_alu.sv
module dual_width_alu
  import dwalu_pkg::*;
#(
  parameter int unsigned XLEN = 64,
  parameter int unsigned IMMW = 32,
  localparam int unsigned SZW = $clog2($clog2(XLEN/8)+1)
) (
  input  logic [4:0]      op_i,
  input  logic            w32_i,
  input  logic            use_imm_i,
  input  logic [SZW-1:0]  size_i,
  input  logic [XLEN-1:0] dst_i,
  input  logic [XLEN-1:0] src_i,
  input  logic [IMMW-1:0] imm_i,
  output logic [XLEN-1:0] res_o,
  output logic            divz_o
);
  localparam int unsigned HALF = XLEN / 2;
  localparam logic [XLEN-1:0] LOW_MASK = {XLEN{1'b1}} >> (XLEN - HALF);

  logic [XLEN-1:0] a_op, b_op;
  logic            b_zero;
  logic [XLEN-1:0] arith_res, shlog_res, byte_res;
  logic            arith_divz;
  alu_cls_e        cls;
  logic [XLEN-1:0] sel_res;

  dwalu_operand #(.XLEN(XLEN), .IMMW(IMMW)) u_opnd (
    .w32_i(w32_i), .use_imm_i(use_imm_i), .dst_i(dst_i), .src_i(src_i),
    .imm_i(imm_i), .a_o(a_op), .b_o(b_op), .b_zero_o(b_zero)
  );

  dwalu_arith #(.XLEN(XLEN)) u_arith (
    .op_i(op_i), .a_i(a_op), .b_i(b_op), .b_zero_i(b_zero),
    .res_o(arith_res), .divz_o(arith_divz)
  );

  dwalu_shlog #(.XLEN(XLEN)) u_shlog (
    .op_i(op_i), .w32_i(w32_i), .a_i(a_op), .b_i(b_op), .res_o(shlog_res)
  );

  dwalu_byteorder #(.XLEN(XLEN)) u_byte (
    .op_i(op_i), .size_i(size_i), .dst_i(dst_i), .b_i(b_op), .res_o(byte_res)
  );

  always_comb begin
    cls = op_class(op_i);
    case (cls)
      CLS_ARITH: sel_res = arith_res;
      CLS_SHLOG: sel_res = shlog_res;
      CLS_BYTE:  sel_res = byte_res;
      default:   sel_res = dst_i;
    endcase
    // byte-order conversions take their width from size_i only
    if (w32_i && cls != CLS_PASS && op_i != OP_TOLE && op_i != OP_TOBE && op_i != OP_BSWAP)
      res_o = sel_res & LOW_MASK;
    else
      res_o = sel_res;
    divz_o = (cls == CLS_ARITH) && arith_divz;
  end
endmodule

// File: rtl/dwalu_chk.sv
module dwalu_chk #(
  parameter int unsigned XLEN = 64,
  parameter int unsigned IMMW = 32
) (
  input logic [4:0]      op_i,
  input logic            w32_i,
  input logic            use_imm_i,
  input logic [XLEN-1:0] dst_i,
  input logic [IMMW-1:0] imm_i,
  input logic [XLEN-1:0] res_o,
  input logic            divz_o
);
  localparam int unsigned HALF = XLEN / 2;

  always_comb begin
    // R7: narrow mode clears the upper half for arithmetic, logic and move ops
    if (w32_i && op_i <= 5'd13)
      a_r7_upper_zero: assert (res_o[XLEN-1:HALF] == '0);
    // R2 / R11: flag only for divide and remainder
    if (divz_o)
      a_r2_flag_op: assert (op_i == 5'd3 || op_i == 5'd4);
    // R2: divide by zero yields zero
    if (divz_o && op_i == 5'd3)
      a_r2_div_zero: assert (res_o == '0);
    // R2: remainder by zero keeps the destination
    if (divz_o && op_i == 5'd4)
      a_r2_mod_keep: assert (res_o[HALF-1:0] == dst_i[HALF-1:0]);
    // R5: negation sums with the destination to zero
    if (op_i == 5'd11 && !w32_i)
      a_r5_neg_sum: assert (XLEN'(res_o + dst_i) == '0);
    // R6: immediate move reproduces the sign-extended field
    if (op_i == 5'd12 && !w32_i && use_imm_i)
      a_r6_imm_sext: assert (res_o[IMMW-1:0] == imm_i &&
                             res_o[XLEN-1:IMMW] == {(XLEN-IMMW){imm_i[IMMW-1]}});
    // R11: unused codes pass the destination through
    if (op_i > 5'd16)
      a_r11_pass: assert (res_o == dst_i && !divz_o);
  end
endmodule

bind dual_width_alu dwalu_chk #(.XLEN(XLEN), .IMMW(IMMW)) u_chk (
  .op_i(op_i), .w32_i(w32_i), .use_imm_i(use_imm_i), .dst_i(dst_i),
  .imm_i(imm_i), .res_o(res_o), .divz_o(divz_o)
);

// File: tb/sim_dual_width_alu.sv
`timescale 1ns/1ps
module sim_dual_width_alu;
  logic        clk;
  logic        rst_n;
  logic [4:0]  op;
  logic        w32, ui;
  logic [1:0]  sz;
  logic [63:0] dst, src;
  logic [31:0] imm;
  logic [63:0] res;
  logic        divz;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  dual_width_alu u0 (
    .op_i(op), .w32_i(w32), .use_imm_i(ui), .size_i(sz),
    .dst_i(dst), .src_i(src), .imm_i(imm), .res_o(res), .divz_o(divz)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic drive(input logic [4:0] o, input logic w, input logic u,
                       input logic [63:0] d, input logic [63:0] s,
                       input logic [31:0] i, input logic [1:0] z);
    @(negedge clk);
    op = o; w32 = w; ui = u; dst = d; src = s; imm = i; sz = z;
    #2;
  endtask

  task automatic chk(input string tag, input logic [63:0] exp_res, input logic exp_dz);
    checks++;
    if (res !== exp_res || divz !== exp_dz) begin
      errors++;
      $display("FAIL %s: got res=%h divz=%0b expected res=%h divz=%0b",
               tag, res, divz, exp_res, exp_dz);
    end
  endtask

  task automatic t_reset;
    drive(5'd0, 0, 0, 64'd0, 64'd0, 32'd0, 2'd0);
    chk("R1 idle zero", 64'd0, 0);
  endtask

  task automatic t_r1_arith;
    drive(5'd0, 0, 0, 64'hFFFF_FFFF_FFFF_FFFF, 64'd2, 0, 0); chk("R1 add wrap", 64'd1, 0);
    drive(5'd1, 0, 0, 64'd5, 64'd7, 0, 0); chk("R1 sub", 64'hFFFF_FFFF_FFFF_FFFE, 0);
    drive(5'd2, 0, 0, 64'h1_0000_0001, 64'h1_0000_0001, 0, 0); chk("R1 mul", 64'h2_0000_0001, 0);
  endtask

  task automatic t_r2_div;
    drive(5'd3, 0, 0, 64'd100, 64'd7, 0, 0); chk("R2 div", 64'd14, 0);
    drive(5'd4, 0, 0, 64'd100, 64'd7, 0, 0); chk("R2 mod", 64'd2, 0);
    drive(5'd3, 0, 0, 64'd100, 64'd0, 0, 0); chk("R2 div zero", 64'd0, 1);
    drive(5'd4, 0, 0, 64'h1234, 64'd0, 0, 0); chk("R2 mod zero", 64'h1234, 1);
    drive(5'd4, 1, 0, 64'hAAAA_BBBB_CCCC_DDDD, 64'h1_0000_0000, 0, 0);
    chk("R2 mod32 zero low", 64'hCCCC_DDDD, 1);
    drive(5'd0, 0, 0, 64'd9, 64'd0, 0, 0); chk("R2 no flag add", 64'd9, 0);
  endtask

  task automatic t_r3_logic;
    drive(5'd5, 0, 0, 64'hF0F0, 64'hFF00, 0, 0); chk("R3 and", 64'hF000, 0);
    drive(5'd6, 0, 0, 64'hF0, 64'h0F, 0, 0); chk("R3 or", 64'hFF, 0);
    drive(5'd7, 0, 0, 64'hFF, 64'h0F, 0, 0); chk("R3 xor", 64'hF0, 0);
  endtask

  task automatic t_r4_shift;
    drive(5'd8, 0, 0, 64'd1, 64'd65, 0, 0); chk("R4 shl mask6", 64'd2, 0);
    drive(5'd8, 1, 0, 64'd1, 64'd33, 0, 0); chk("R4 shl mask5", 64'd2, 0);
    drive(5'd9, 0, 0, 64'h8000_0000_0000_0000, 64'd63, 0, 0); chk("R4 shr", 64'd1, 0);
    drive(5'd10, 0, 0, 64'h8000_0000_0000_0000, 64'd4, 0, 0); chk("R4 sar64", 64'hF800_0000_0000_0000, 0);
    drive(5'd10, 1, 0, 64'h8000_0000, 64'd4, 0, 0); chk("R4 sar32", 64'hF800_0000, 0);
    drive(5'd9, 1, 0, 64'hFFFF_FFFF_8000_0000, 64'd31, 0, 0); chk("R4 shr32", 64'd1, 0);
  endtask

  task automatic t_r5_negmov;
    drive(5'd11, 0, 0, 64'd1, 0, 0, 0); chk("R5 neg", 64'hFFFF_FFFF_FFFF_FFFF, 0);
    drive(5'd12, 0, 0, 64'd3, 64'h1122_3344_5566_7788, 0, 0); chk("R5 mov", 64'h1122_3344_5566_7788, 0);
  endtask

  task automatic t_r6_imm;
    drive(5'd0, 0, 1, 64'd10, 64'd999, 32'hFFFF_FFFE, 0); chk("R6 add imm neg", 64'd8, 0);
    drive(5'd12, 0, 1, 0, 0, 32'h8000_0000, 0); chk("R6 mov imm", 64'hFFFF_FFFF_8000_0000, 0);
    drive(5'd3, 0, 1, 64'hFFFF_FFFF_FFFF_FFFF, 0, 32'hFFFF_FFFF, 0); chk("R6 div imm", 64'd1, 0);
  endtask

  task automatic t_r7_narrow;
    drive(5'd0, 1, 0, 64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 0, 0); chk("R7 add32", 64'd0, 0);
    drive(5'd2, 1, 0, 64'h1_0000_0003, 64'd5, 0, 0); chk("R7 mul32", 64'd15, 0);
    drive(5'd11, 1, 0, 64'd1, 0, 0, 0); chk("R7 neg32", 64'hFFFF_FFFF, 0);
    drive(5'd12, 1, 1, 0, 0, 32'h8000_0000, 0); chk("R7 mov32 imm", 64'h8000_0000, 0);
    drive(5'd0, 1, 1, 64'd10, 0, 32'hFFFF_FFFE, 0); chk("R7 add32 imm", 64'd8, 0);
  endtask

  task automatic t_r8_movsx;
    drive(5'd13, 0, 0, 0, 64'h80, 0, 2'd0); chk("R8 sx8", 64'hFFFF_FFFF_FFFF_FF80, 0);
    drive(5'd13, 0, 0, 0, 64'h7FFF_1234, 0, 2'd1); chk("R8 sx16", 64'h1234, 0);
    drive(5'd13, 0, 0, 0, 64'h8000_0001, 0, 2'd2); chk("R8 sx32", 64'hFFFF_FFFF_8000_0001, 0);
    drive(5'd13, 0, 0, 0, 64'hDEAD_BEEF_0000_0001, 0, 2'd3); chk("R8 copy", 64'hDEAD_BEEF_0000_0001, 0);
    drive(5'd13, 1, 0, 0, 64'h80, 0, 2'd0); chk("R8 sx8 narrow", 64'hFFFF_FF80, 0);
  endtask

  task automatic t_r9_r10_bytes;
    logic [63:0] v;
    v = 64'h1122_3344_5566_7788;
    drive(5'd14, 0, 0, v, 0, 0, 2'd1); chk("R9 le16", 64'h7788, 0);
    drive(5'd14, 0, 0, v, 0, 0, 2'd2); chk("R9 le32", 64'h5566_7788, 0);
    drive(5'd14, 1, 0, v, 0, 0, 2'd3); chk("R9 le64 ignores w32", v, 0);
    drive(5'd15, 0, 0, v, 0, 0, 2'd1); chk("R10 be16", 64'h8877, 0);
    drive(5'd15, 0, 0, v, 0, 0, 2'd2); chk("R10 be32", 64'h8877_6655, 0);
    drive(5'd15, 1, 0, v, 0, 0, 2'd3); chk("R10 be64 ignores w32", 64'h8877_6655_4433_2211, 0);
    drive(5'd16, 0, 0, v, 0, 0, 2'd2); chk("R10 bswap32", 64'h8877_6655, 0);
  endtask

  task automatic t_r11_unused;
    drive(5'd20, 1, 0, 64'hCAFE_0000_1234_5678, 64'd0, 0, 0); chk("R11 unused code", 64'hCAFE_0000_1234_5678, 0);
  endtask

  initial begin
    rst_n = 1'b0;
    op = '0; w32 = 0; ui = 0; sz = '0; dst = '0; src = '0; imm = '0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    t_reset();
    t_r1_arith();
    t_r2_div();
    t_r3_logic();
    t_r4_shift();
    t_r5_negmov();
    t_r6_imm();
    t_r7_narrow();
    t_r8_movsx();
    t_r9_r10_bytes();
    t_r11_unused();
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #2_000_000;
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got running expected finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule